// File: doc/BRIEF.md
# Subroutine Return Stack Unit

This unit keeps the return stack of a small microcontroller in its internal scratchpad RAM. A call request brings in the 12-bit program counter and the 8-bit status word. The unit writes the counter and the upper status nibble into the stack slot that the 3-bit stack pointer selects, then advances the pointer. A return request steps the pointer back and reads that slot to restore the program counter. An interrupt return does the same and also restores the upper status nibble.

Each stack operation uses the RAM for two byte cycles. The low byte of a slot holds counter bits 7:0. The high byte holds counter bits 11:8 in its low nibble and status bits 7:4 in its high nibble. The stack pointer is always visible in the low three bits of the status word that the unit drives out. The RAM itself and the program counter logic sit outside the unit. The RAM answers a read one clock after the address cycle.

Top module: `retstack_unit`

## Requirements
- R1: After reset the pointer is 0, `psw_out` reads 08h, `pc_out` reads 0, and `ram_we`, `ram_re`, `done` and `restore_valid` are all low.
- R2: A call writes the low byte (PC bits 7:0) at address 08h+2·SP in the first cycle after acceptance. In the next cycle it writes the high byte (status bits 7:4 above PC bits 11:8) at 09h+2·SP, with `ram_we` high in both cycles.
- R3: The pointer advances by one when a call finishes, wrapping from 7 to 0. `done` is high for exactly one cycle, right after the second write, and `restore_valid` stays low during a call.
- R4: A plain return reads 08h+2·SP' and then 09h+2·SP' with `ram_re` high, where SP' is the decremented pointer. Two cycles after the second read cycle, `done` and `restore_valid` pulse together and `pc_out` holds the slot's 12-bit counter. The upper status nibble is unchanged.
- R5: An interrupt return behaves like R4 and also loads `psw_out[7:4]` from the high nibble of the slot's high byte.
- R6: A pop with the pointer at 0 wraps it to 7. No error is flagged.
- R7: `psw_out` is always {upper status nibble, 1, pointer}. During a pop, the decremented pointer shows from the first read cycle onward.
- R8: Requests that arrive while an operation is in progress have no effect on the pointer, the RAM traffic or the outputs.
- R9: Simultaneous requests in the idle state resolve as call, then interrupt return, then plain return.
- R10: `ram_we` and `ram_re` are never high together, and every access lies in 08h..17h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| call_req | input | 1 | Push request |
| call_pc | input | 12 | Counter to save |
| call_psw | input | 8 | Status word to save (bits 7:4 kept) |
| ret_req | input | 1 | Plain return request |
| reti_req | input | 1 | Interrupt return request |
| ram_addr | output | 6 | Scratchpad byte address |
| ram_wdata | output | 8 | Byte to write |
| ram_we | output | 1 | Write strobe |
| ram_re | output | 1 | Read strobe |
| ram_rdata | input | 8 | Read byte, one cycle after `ram_re` |
| pc_out | output | 12 | Restored counter |
| psw_out | output | 8 | Status word with live pointer |
| restore_valid | output | 1 | Pulse when a pop result is ready |
| done | output | 1 | Pulse at the end of each push or pop |

## Verification
A pointer that drifts shows up at once in `psw_out[2:0]` and in the address of the next access. A mis-sequenced state machine puts an access outside the 08h..17h window, breaks the low/high address pairing, or makes `done` last more than one cycle. Any of these is caught within the same operation. A corrupted slot byte can only be seen when that slot is popped, possibly many operations later. For this reason the random runs mix deep call chains with returns that wrap the pointer, and requests are injected during busy cycles so that any leakage moves the pointer.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_LO,
      ST_WR_HI,
      ST_RD_LO,
      ST_RD_HI,
      ST_RD_FIN
   } rs_state_t;
endpackage

// File: rtl/rs_ptr.sv
module rs_ptr #(
   parameter int SP_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   input  logic            dec,
   output logic [SP_W-1:0] sp
);
   // modular counter: wraps silently both ways
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sp <= '0;
      else if (inc) sp <= sp + 1'b1;
      else if (dec) sp <= sp - 1'b1;
   end
endmodule

// File: rtl/rs_addr.sv
module rs_addr #(
   parameter int ADDR_W = 6,
   parameter int SP_W   = 3,
   parameter int BASE   = 8
) (
   input  logic [SP_W-1:0]   sp,
   input  logic              hi_sel,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
   // two bytes per slot: low byte even offset, high byte odd
   assign addr = BASE_A + ADDR_W'({sp, hi_sel});
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
   import rs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic call_req,
   input  logic ret_req,
   input  logic reti_req,
   output logic take_call,
   output logic take_pop,
   output logic ram_we,
   output logic ram_re,
   output logic hi_sel,
   output logic inc,
   output logic cap_lo,
   output logic load,
   output logic reti_q,
   output logic done,
   output logic restore_valid
);
   rs_state_t state_q, state_d;
   logic      idle;

   assign idle      = (state_q == ST_IDLE);
   assign take_call = idle & call_req;
   assign take_pop  = idle & ~call_req & (ret_req | reti_req);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (call_req) state_d = ST_WR_LO;
                    else if (ret_req | reti_req) state_d = ST_RD_LO;
         ST_WR_LO:  state_d = ST_WR_HI;
         ST_WR_HI:  state_d = ST_IDLE;
         ST_RD_LO:  state_d = ST_RD_HI;
         ST_RD_HI:  state_d = ST_RD_FIN;
         ST_RD_FIN: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   assign ram_we = (state_q == ST_WR_LO) | (state_q == ST_WR_HI);
   assign ram_re = (state_q == ST_RD_LO) | (state_q == ST_RD_HI);
   assign hi_sel = (state_q == ST_WR_HI) | (state_q == ST_RD_HI);
   assign inc    = (state_q == ST_WR_HI);
   assign cap_lo = (state_q == ST_RD_HI);
   assign load   = (state_q == ST_RD_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         reti_q        <= 1'b0;
         done          <= 1'b0;
         restore_valid <= 1'b0;
      end else begin
         state_q       <= state_d;
         done          <= inc | load;
         restore_valid <= load;
         if (take_pop) reti_q <= reti_req;
      end
   end

   // R3: completion strobe never stretches
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4: a restore is always reported with completion
   assert_valid_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid |-> done);
endmodule

// File: rtl/retstack_unit.sv
module retstack_unit #(
   parameter int PC_W   = 12,
   parameter int ST_W   = 8,
   parameter int SP_W   = 3,
   parameter int ADDR_W = 6,
   parameter int BASE   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_req,
   input  logic [PC_W-1:0]   call_pc,
   input  logic [ST_W-1:0]   call_psw,
   input  logic              ret_req,
   input  logic              reti_req,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              ram_we,
   output logic              ram_re,
   input  logic [7:0]        ram_rdata,
   output logic [PC_W-1:0]   pc_out,
   output logic [ST_W-1:0]   psw_out,
   output logic              restore_valid,
   output logic              done
);
   localparam int DEPTH  = 1 << SP_W;
   localparam int HI_PC  = PC_W - 8;
   localparam int SAVE_W = 8 - HI_PC;
   localparam int PAD_W  = ST_W - SAVE_W - SP_W;
   localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(BASE + 2 * DEPTH - 1);

   // elaboration-time parameter checks
   if (PC_W <= 8 || PC_W >= 16) begin : g_bad_pc
      $error("PC_W must lie between 9 and 15");
   end
   if (PAD_W < 0) begin : g_bad_st
      $error("status word too narrow for saved bits plus pointer");
   end
   if (BASE + 2 * DEPTH > (1 << ADDR_W)) begin : g_bad_addr
      $error("stack region exceeds RAM address space");
   end

   logic [SP_W-1:0]   sp;
   logic              take_call, take_pop, hi_sel, inc, cap_lo, load, reti_q;
   logic [PC_W-1:0]   pc_q;
   logic [SAVE_W-1:0] sv_q;
   logic [7:0]        lo_q;
   logic [SAVE_W-1:0] psw_hi;
   logic              unused_psw_low;

   assign unused_psw_low = ^call_psw[ST_W-SAVE_W-1:0];

   rs_ctrl u_ctrl (
      .clk, .rst_n, .call_req, .ret_req, .reti_req,
      .take_call, .take_pop, .ram_we, .ram_re, .hi_sel,
      .inc, .cap_lo, .load, .reti_q, .done, .restore_valid
   );

   rs_ptr #(.SP_W(SP_W)) u_ptr (
      .clk, .rst_n, .inc, .dec(take_pop), .sp
   );

   rs_addr #(.ADDR_W(ADDR_W), .SP_W(SP_W), .BASE(BASE)) u_addr (
      .sp, .hi_sel, .addr(ram_addr)
   );

   assign ram_wdata = hi_sel ? {sv_q, pc_q[PC_W-1:8]} : pc_q[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         sv_q   <= '0;
         lo_q   <= '0;
         pc_out <= '0;
         psw_hi <= '0;
      end else begin
         if (take_call) begin
            pc_q <= call_pc;
            sv_q <= call_psw[ST_W-1 -: SAVE_W];
         end
         if (cap_lo) lo_q <= ram_rdata;
         if (load) begin
            pc_out <= {ram_rdata[HI_PC-1:0], lo_q};
            if (reti_q) psw_hi <= ram_rdata[7:HI_PC];
         end
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign psw_out = {psw_hi, {PAD_W{1'b1}}, sp};
   end else begin : g_nopad
      assign psw_out = {psw_hi, sp};
   end

   // R10: RAM is driven one way at a time
   assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_we, ram_re}));
   // R10: accesses stay in the stack window
   assert_addr_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we | ram_re) |-> (ram_addr >= FIRST_A && ram_addr <= LAST_A));
   // R2: low-byte write is followed by the high byte of the same slot
   assert_write_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !ram_addr[0]) |=> (ram_we && ram_addr == $past(ram_addr) + 1'b1));
   // R4: low-byte read is followed by the high byte of the same slot
   assert_read_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_re && !ram_addr[0]) |=> (ram_re && ram_addr == $past(ram_addr) + 1'b1));
endmodule

// File: tb/sim_retstack_unit.sv
module sim_retstack_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_req = 1'b0, ret_req = 1'b0, reti_req = 1'b0;
   logic [11:0] call_pc = '0;
   logic [7:0]  call_psw = '0;
   logic [5:0]  ram_addr;
   logic [7:0]  ram_wdata, ram_rdata;
   logic        ram_we, ram_re;
   logic [11:0] pc_out;
   logic [7:0]  psw_out;
   logic        restore_valid, done;

   int vectors = 0, miscompares = 0, cyc = 0;
   logic [7:0] mem [64];
   logic [7:0] slot_lo [8];
   logic [7:0] slot_hi [8];
   int exp_sp = 0;
   logic [11:0] exp_pc = '0;
   logic [3:0]  exp_hi = '0;

   always #10 clk = ~clk;   // 50 MHz

   retstack_unit u0 (.*);

   always @(posedge clk) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      if (ram_re) ram_rdata <= mem[ram_addr];
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         miscompares++;
         $display("FAIL watchdog act=%0d exp=done", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   function automatic logic [5:0] f_addr(int sp, bit hi);
      return 6'(8 + 2 * sp + (hi ? 1 : 0));
   endfunction
   function automatic logic [7:0] f_psw(logic [3:0] hi, int sp);
      return {hi, 1'b1, 3'(sp)};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // kind: 0 call, 1 ret, 2 reti, 3 all three (call wins), 4 ret+reti (reti wins)
   task automatic do_op(int kind, logic [11:0] pc, logic [7:0] psw, bit noise);
      bit push, intr;
      int sp_old;
      push = (kind == 0 || kind == 3);
      intr = (kind == 2 || kind == 4);
      @(negedge clk);
      chk("R10 idle no access", 32'({ram_we, ram_re, done}), 32'd0);
      chk("R7 idle status", 32'(psw_out), 32'(f_psw(exp_hi, exp_sp)));
      call_req = push;
      ret_req  = (kind == 1 || kind == 3 || kind == 4);
      reti_req = (kind == 2 || kind == 3 || kind == 4);
      call_pc = pc; call_psw = psw;
      sp_old = exp_sp;
      @(negedge clk);
      if (noise) begin
         call_req = 1'($urandom); ret_req = 1'($urandom); reti_req = 1'($urandom);
         call_pc = 12'($urandom); call_psw = 8'($urandom);
      end else begin
         call_req = 0; ret_req = 0; reti_req = 0;
      end
      if (push) begin
         chk("R2 R9 low write strobe", 32'({ram_we, ram_re}), 32'b10);
         chk("R2 low addr", 32'(ram_addr), 32'(f_addr(exp_sp, 0)));
         chk("R2 low data", 32'(ram_wdata), 32'(pc[7:0]));
         @(negedge clk);
         call_req = 0; ret_req = 0; reti_req = 0;
         chk("R2 high write strobe", 32'({ram_we, ram_re}), 32'b10);
         chk("R2 high addr", 32'(ram_addr), 32'(f_addr(exp_sp, 1)));
         chk("R2 high data", 32'(ram_wdata), 32'({psw[7:4], pc[11:8]}));
         slot_lo[exp_sp] = pc[7:0];
         slot_hi[exp_sp] = {psw[7:4], pc[11:8]};
         exp_sp = (exp_sp + 1) % 8;
         @(negedge clk);
         chk("R3 done pulse, no restore", 32'({done, restore_valid}), 32'b10);
         chk(sp_old == 7 ? "R3 wrap 7 to 0" : "R3 R8 pointer advance",
             32'(psw_out[2:0]), 32'(exp_sp));
      end else begin
         exp_sp = (exp_sp + 7) % 8;
         chk("R4 R9 low read strobe", 32'({ram_we, ram_re}), 32'b01);
         chk("R4 low read addr", 32'(ram_addr), 32'(f_addr(exp_sp, 0)));
         chk(sp_old == 0 ? "R6 underflow wrap" : "R7 early pointer",
             32'(psw_out[2:0]), 32'(exp_sp));
         @(negedge clk);
         call_req = 0; ret_req = 0; reti_req = 0;
         chk("R4 high read addr", 32'({ram_re, ram_addr}), 32'({1'b1, f_addr(exp_sp, 1)}));
         @(negedge clk);
         chk("R4 R8 quiet final cycle", 32'({ram_we, ram_re, done}), 32'd0);
         @(negedge clk);
         exp_pc = {slot_hi[exp_sp][3:0], slot_lo[exp_sp]};
         if (intr) exp_hi = slot_hi[exp_sp][7:4];
         chk("R4 done and valid", 32'({done, restore_valid}), 32'b11);
         chk("R4 restored pc", 32'(pc_out), 32'(exp_pc));
         chk(intr ? "R5 restored status" : "R4 status kept",
             32'(psw_out), 32'(f_psw(exp_hi, exp_sp)));
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) mem[i] = '0;
      for (int i = 0; i < 8; i++) begin slot_lo[i] = '0; slot_hi[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R1 reset status", 32'(psw_out), 32'h08);
      chk("R1 reset pc", 32'(pc_out), 32'd0);
      chk("R1 reset strobes", 32'({ram_we, ram_re, done, restore_valid}), 32'd0);
      rst_n = 1'b1;
      // underflow from an empty stack
      do_op(1, '0, '0, 0);
      do_op(0, 12'h123, 8'hA5, 0);
      // fill past the top to wrap the pointer
      for (int i = 0; i < 9; i++) do_op(0, 12'(12'h100 + i * 12'h111), 8'(i * 8'h17), 0);
      for (int i = 0; i < 10; i++) do_op((i % 2) ? 2 : 1, '0, '0, 0);
      // priority cases
      do_op(3, 12'hFED, 8'hC3, 0);
      do_op(4, '0, '0, 0);
      do_op(3, 12'h0AB, 8'h5A, 1);
      do_op(4, '0, '0, 1);
      // random mix with busy-time noise on the request lines
      for (int i = 0; i < 400; i++) begin
         int k;
         k = int'($urandom_range(0, 9));
         do_op(k < 4 ? 0 : (k < 6 ? 1 : (k < 8 ? 2 : (k == 8 ? 3 : 4))),
               12'($urandom), 8'($urandom), 1'($urandom));
      end
      @(negedge clk);
      chk("R3 done single cycle", 32'(done), 32'd0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule